// File: doc/BRIEF.md
# Display RAM write address counter

This block turns a stream of byte writes from a host into write addresses for a display RAM of 133 columns and 9 row banks of 8 rows each. The column pointer is a 7-bit value together with a one-bit page extension, so the logical column is the 7-bit value plus 128 times the page bit. The bank pointer is 4 bits wide. The last bank holds icon data and is only one bit deep.

After each accepted byte the pointers advance automatically. In horizontal scan the column moves first and the bank follows on column wrap. In vertical scan the bank moves first and the column follows on bank wrap. The host can load the 7-bit column value, the page bit and the bank independently, and can select scan direction and column mirroring. Each accepted write produces a one-cycle strobe carrying the physical column, the bank, the byte and a per-bit write mask for a behavioural RAM. Writes to a position outside the array are flagged and dropped.

Top module: `dram_wr_addr`

## Requirements
- R1: After reset the pointers select logical column 0 and bank 0, horizontal scan and no mirroring are selected, and ram_we and addr_err are 0.
- R2: With mirroring off the physical column on ram_col equals X + 128*P, where X is the 7-bit column value (ld_value[6:0] on ld_x) and P the page bit (ld_value[0] on ld_xpage).
- R3: With mirroring on (mode_mirror=1 on mode_we) ram_col equals 132 minus the logical column; X=0,P=0 gives 132 and X=4,P=1 gives 0.
- R4: In horizontal scan (mode_vert=0) each accepted write advances the logical column by one; after column 132 the column returns to 0 and the bank advances, and after bank 8 the bank returns to 0.
- R5: In vertical scan (mode_vert=1) each accepted write advances the bank by one; after bank 8 the bank returns to 0 and the logical column advances, returning from 132 to 0.
- R6: A write to bank 8 drives ram_mask = 8'h80 and ram_data with bits 6:0 forced to 0; other banks drive ram_mask = 8'hFF and the byte unchanged.
- R7: A write whose logical column exceeds 132 or whose bank (ld_value[3:0] on ld_y) exceeds 8 produces no strobe, pulses addr_err for one cycle and leaves both pointers unchanged.
- R8: Loads of X, P and bank change only the loaded field and cause no advance; the next write uses the loaded values. A write presented in the same cycle as any load or mode update is dropped with no strobe.
- R9: ram_we, ram_col, ram_bank, ram_data, ram_mask and addr_err are registered: they reflect a write presented in one cycle during the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write request |
| wr_byte | input | 8 | Byte to write |
| ld_x | input | 1 | Load the 7-bit column value from ld_value[6:0] |
| ld_xpage | input | 1 | Load the page bit from ld_value[0] |
| ld_y | input | 1 | Load the bank from ld_value[3:0] |
| ld_value | input | 7 | Value for pointer loads |
| mode_we | input | 1 | Update scan direction and mirroring |
| mode_vert | input | 1 | 1 selects vertical scan |
| mode_mirror | input | 1 | 1 selects mirrored columns |
| ram_we | output | 1 | RAM write strobe |
| ram_col | output | 8 | Physical column index |
| ram_bank | output | 4 | Bank index |
| ram_data | output | 8 | Byte to store |
| ram_mask | output | 8 | Per-bit write enable |
| addr_err | output | 1 | Illegal address pulse |

## Verification
The bench walks every position of the array in both scan directions and in mirrored horizontal scan, so a counter that wrapped one column early or late, forgot to carry into the other pointer, or mapped the mirror off by one would misplace a byte somewhere in the sweep. Bank 8 writes are checked for the reduced mask, which a design ignoring the icon bank would report as a full byte. Illegal column and bank positions are hit and followed by a repair load of only the other field, exposing a design that advanced or wrote anyway. A write colliding with a load exposes a design that let the write through or advanced past the loaded value.

// File: rtl/dram_wr_pkg.sv
package dram_wr_pkg;
   typedef enum logic {
      SCAN_HORIZ = 1'b0,
      SCAN_VERT  = 1'b1
   } scan_mode_e;

   localparam int DEF_X_W       = 7;
   localparam int DEF_Y_W       = 4;
   localparam int DEF_NUM_COLS  = 133;
   localparam int DEF_NUM_BANKS = 9;
   localparam int DEF_DATA_W    = 8;
   localparam int DEF_LAST_BITS = 1;
endpackage

// File: rtl/dram_wr_ptr.sv
module dram_wr_ptr
   import dram_wr_pkg::*;
#(
   parameter int COL_W     = 8,
   parameter int Y_W       = 4,
   parameter int NUM_COLS  = 133,
   parameter int NUM_BANKS = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  scan_mode_e       scan,
   input  logic             ld_x,
   input  logic             ld_page,
   input  logic             ld_y,
   input  logic [COL_W-2:0] ld_value,
   input  logic             illegal_wr,
   output logic [COL_W-1:0] col_q,
   output logic [Y_W-1:0]   y_q
);
   localparam int X_W = COL_W - 1;
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);
   localparam logic [Y_W-1:0]   LAST_Y   = Y_W'(NUM_BANKS - 1);

   logic [COL_W-1:0] col_d, col_inc;
   logic [Y_W-1:0]   y_d, y_inc;
   logic             col_wrap, y_wrap, any_ld;

   assign any_ld   = ld_x | ld_page | ld_y;
   assign col_wrap = (col_q == LAST_COL);
   assign y_wrap   = (y_q == LAST_Y);
   assign col_inc  = col_wrap ? '0 : col_q + COL_W'(1);
   assign y_inc    = y_wrap ? '0 : y_q + Y_W'(1);

   always_comb begin
      col_d = col_q;
      y_d   = y_q;
      if (any_ld) begin
         if (ld_x)    col_d[X_W-1:0] = ld_value;
         if (ld_page) col_d[COL_W-1] = ld_value[0];
         if (ld_y)    y_d = ld_value[Y_W-1:0];
      end else if (adv) begin
         if (scan == SCAN_VERT) begin
            y_d = y_inc;
            if (y_wrap) col_d = col_inc;
         end else begin
            col_d = col_inc;
            if (col_wrap) y_d = y_inc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         y_q   <= '0;
      end else begin
         col_q <= col_d;
         y_q   <= y_d;
      end
   end

   // R4: horizontal step inside a row of banks keeps the bank
   a_r4_horiz_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !any_ld && scan == SCAN_HORIZ && !col_wrap)
         |=> (col_q == $past(col_q) + COL_W'(1)) && $stable(y_q));

   // R5: vertical step below the last bank keeps the column
   a_r5_vert_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !any_ld && scan == SCAN_VERT && !y_wrap)
         |=> (y_q == $past(y_q) + Y_W'(1)) && $stable(col_q));

   // R7: a rejected write leaves the pointers alone
   a_r7_hold_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal_wr && !any_ld) |=> $stable(col_q) && $stable(y_q));
endmodule

// File: rtl/dram_wr_colmap.sv
module dram_wr_colmap #(
   parameter int COL_W     = 8,
   parameter int NUM_COLS  = 133,
   parameter bit MIRROR_EN = 1'b1
) (
   input  logic [COL_W-1:0] logical_col,
   input  logic             mirror,
   output logic [COL_W-1:0] phys_col
);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

   generate
      if (MIRROR_EN) begin : g_mirror
         assign phys_col = mirror ? (LAST_COL - logical_col) : logical_col;
      end else begin : g_direct
         logic unused_mirror;
         assign unused_mirror = mirror;
         assign phys_col = logical_col;
      end
   endgenerate
endmodule

// File: rtl/dram_wr_out.sv
module dram_wr_out #(
   parameter int COL_W     = 8,
   parameter int Y_W       = 4,
   parameter int DATA_W    = 8,
   parameter int NUM_COLS  = 133,
   parameter int NUM_BANKS = 9,
   parameter int LAST_BITS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic              wr_bad,
   input  logic [COL_W-1:0]  col_in,
   input  logic [Y_W-1:0]    bank_in,
   input  logic [DATA_W-1:0] byte_in,
   output logic              ram_we,
   output logic [COL_W-1:0]  ram_col,
   output logic [Y_W-1:0]    ram_bank,
   output logic [DATA_W-1:0] ram_data,
   output logic [DATA_W-1:0] ram_mask,
   output logic              addr_err
);
   localparam logic [Y_W-1:0] LAST_Y = Y_W'(NUM_BANKS - 1);

   logic              is_last;
   logic [DATA_W-1:0] mask_d;

   assign is_last = (bank_in == LAST_Y);

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         if (i >= DATA_W - LAST_BITS) begin : g_keep
            assign mask_d[i] = 1'b1;
         end else begin : g_drop
            assign mask_d[i] = ~is_last;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_we   <= 1'b0;
         addr_err <= 1'b0;
         ram_col  <= '0;
         ram_bank <= '0;
         ram_data <= '0;
         ram_mask <= '0;
      end else begin
         ram_we   <= wr_ok;
         addr_err <= wr_bad;
         if (wr_ok) begin
            ram_col  <= col_in;
            ram_bank <= bank_in;
            ram_data <= byte_in & mask_d;
            ram_mask <= mask_d;
         end
      end
   end

   // R7: an error never comes with a strobe
   a_r7_err_no_we: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> !ram_we);

   // R3: every strobed column lies inside the array
   a_r3_col_range: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (int'(ram_col) < NUM_COLS));

   // R6: strobed bank inside the array, narrow mask on the last bank
   a_r6_last_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && ram_bank == LAST_Y) |-> ($countones(ram_mask) == LAST_BITS)
                                         && ((ram_data & ~ram_mask) == '0));

   a_r6_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (int'(ram_bank) < NUM_BANKS));
endmodule

// File: rtl/dram_wr_addr.sv
module dram_wr_addr
   import dram_wr_pkg::*;
#(
   parameter int X_W       = DEF_X_W,
   parameter int Y_W       = DEF_Y_W,
   parameter int NUM_COLS  = DEF_NUM_COLS,
   parameter int NUM_BANKS = DEF_NUM_BANKS,
   parameter int DATA_W    = DEF_DATA_W,
   parameter int LAST_BITS = DEF_LAST_BITS,
   parameter bit MIRROR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              ld_x,
   input  logic              ld_xpage,
   input  logic              ld_y,
   input  logic [X_W-1:0]    ld_value,
   input  logic              mode_we,
   input  logic              mode_vert,
   input  logic              mode_mirror,
   output logic              ram_we,
   output logic [X_W:0]      ram_col,
   output logic [Y_W-1:0]    ram_bank,
   output logic [DATA_W-1:0] ram_data,
   output logic [DATA_W-1:0] ram_mask,
   output logic              addr_err
);
   localparam int COL_W = X_W + 1;

   generate
      if (NUM_COLS > (1 << COL_W) || NUM_COLS < 2) begin : g_bad_cols
         $error("dram_wr_addr: NUM_COLS does not fit the column pointer");
      end
      if (NUM_BANKS > (1 << Y_W) || NUM_BANKS < 2) begin : g_bad_banks
         $error("dram_wr_addr: NUM_BANKS does not fit the bank pointer");
      end
      if (Y_W > X_W) begin : g_bad_load
         $error("dram_wr_addr: bank pointer wider than load value");
      end
      if (LAST_BITS < 1 || LAST_BITS > DATA_W) begin : g_bad_last
         $error("dram_wr_addr: LAST_BITS out of range");
      end
   endgenerate

   scan_mode_e       scan_q;
   logic             mirror_q;
   logic [COL_W-1:0] col_q, phys_col;
   logic [Y_W-1:0]   y_q;
   logic             any_ld, accept, legal, wr_ok, wr_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_q   <= SCAN_HORIZ;
         mirror_q <= 1'b0;
      end else if (mode_we) begin
         scan_q   <= mode_vert ? SCAN_VERT : SCAN_HORIZ;
         mirror_q <= mode_mirror;
      end
   end

   assign any_ld = ld_x | ld_xpage | ld_y | mode_we;
   assign accept = wr_en & ~any_ld;
   assign legal  = (int'(col_q) < NUM_COLS) && (int'(y_q) < NUM_BANKS);
   assign wr_ok  = accept & legal;
   assign wr_bad = accept & ~legal;

   dram_wr_ptr #(
      .COL_W(COL_W), .Y_W(Y_W), .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS)
   ) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv(wr_ok), .scan(scan_q),
      .ld_x(ld_x), .ld_page(ld_xpage), .ld_y(ld_y), .ld_value(ld_value),
      .illegal_wr(wr_bad), .col_q(col_q), .y_q(y_q)
   );

   dram_wr_colmap #(
      .COL_W(COL_W), .NUM_COLS(NUM_COLS), .MIRROR_EN(MIRROR_EN)
   ) u_map (
      .logical_col(col_q), .mirror(mirror_q), .phys_col(phys_col)
   );

   dram_wr_out #(
      .COL_W(COL_W), .Y_W(Y_W), .DATA_W(DATA_W),
      .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .LAST_BITS(LAST_BITS)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_bad(wr_bad),
      .col_in(phys_col), .bank_in(y_q), .byte_in(wr_byte),
      .ram_we(ram_we), .ram_col(ram_col), .ram_bank(ram_bank),
      .ram_data(ram_data), .ram_mask(ram_mask), .addr_err(addr_err)
   );

   // R8: a write colliding with a load or mode update yields no strobe
   a_r8_load_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
      (any_ld) |=> !ram_we && !addr_err);

   // R9: strobe appears only in the cycle after a write request
   a_r9_strobe_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !ram_we && !addr_err);
endmodule

// File: tb/dram_wr_addr_tb.sv
module dram_wr_addr_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_byte = '0;
   logic       ld_x = 1'b0, ld_xpage = 1'b0, ld_y = 1'b0;
   logic [6:0] ld_value = '0;
   logic       mode_we = 1'b0, mode_vert = 1'b0, mode_mirror = 1'b0;
   logic       ram_we, addr_err;
   logic [7:0] ram_col, ram_data, ram_mask;
   logic [3:0] ram_bank;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model of the pointers
   int m_col = 0, m_y = 0;
   bit m_vert = 0, m_mir = 0;

   always #4 clk = ~clk;

   dram_wr_addr u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
      .ld_x(ld_x), .ld_xpage(ld_xpage), .ld_y(ld_y), .ld_value(ld_value),
      .mode_we(mode_we), .mode_vert(mode_vert), .mode_mirror(mode_mirror),
      .ram_we(ram_we), .ram_col(ram_col), .ram_bank(ram_bank),
      .ram_data(ram_data), .ram_mask(ram_mask), .addr_err(addr_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic advance();
      if (m_vert) begin
         if (m_y == 8) begin
            m_y = 0;
            m_col = (m_col == 132) ? 0 : m_col + 1;
         end else m_y++;
      end else begin
         if (m_col == 132) begin
            m_col = 0;
            m_y = (m_y == 8) ? 0 : m_y + 1;
         end else m_col++;
      end
   endtask

   // one write, checked in the cycle after it was presented
   task automatic wr(input logic [7:0] b, input string req);
      bit legal;
      int ecol;
      logic [7:0] emask;
      @(negedge clk);
      wr_en = 1'b1; wr_byte = b;
      @(negedge clk);
      wr_en = 1'b0;
      legal = (m_col <= 132) && (m_y <= 8);
      if (legal) begin
         ecol  = m_mir ? 132 - m_col : m_col;
         emask = (m_y == 8) ? 8'h80 : 8'hFF;
         chk(ram_we === 1'b1 && addr_err === 1'b0, req, int'(ram_we), 1);
         chk(int'(ram_col) == ecol && int'(ram_bank) == m_y,
             req, int'(ram_col) * 16 + int'(ram_bank), ecol * 16 + m_y);
         chk(ram_mask === emask && ram_data === (b & emask),
             (m_y == 8) ? "R6" : req, int'(ram_data), int'(b & emask));
         advance();
      end else begin
         chk(ram_we === 1'b0 && addr_err === 1'b1, "R7",
             int'(ram_we) * 2 + int'(addr_err), 1);
      end
   endtask

   task automatic load(input bit lx, input bit lp, input bit ly, input int v);
      @(negedge clk);
      ld_x = lx; ld_xpage = lp; ld_y = ly; ld_value = 7'(v);
      @(negedge clk);
      ld_x = 1'b0; ld_xpage = 1'b0; ld_y = 1'b0;
      if (lx) m_col = (m_col & 128) | (v & 127);
      if (lp) m_col = (m_col & 127) | ((v & 1) * 128);
      if (ly) m_y = v & 15;
      chk(ram_we === 1'b0, "R8", int'(ram_we), 0);
   endtask

   task automatic set_mode(input bit v, input bit m);
      @(negedge clk);
      mode_we = 1'b1; mode_vert = v; mode_mirror = m;
      @(negedge clk);
      mode_we = 1'b0;
      m_vert = v; m_mir = m;
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(ram_we === 1'b0 && addr_err === 1'b0, "R1", int'(ram_we), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ram_we === 1'b0, "R1", int'(ram_we), 0);
      wr(8'h5A, "R1");
      // R9: strobe is a single cycle
      @(negedge clk);
      chk(ram_we === 1'b0, "R9", int'(ram_we), 0);

      // R4: full horizontal sweep with wrap of both pointers
      for (int i = 0; i < 133 * 9 + 5; i++) wr(8'((i * 37) ^ 8'hC3), "R4");

      // R2 / R8: loads take effect without an increment
      load(1, 0, 0, 4);
      load(0, 1, 0, 1);
      load(0, 0, 1, 3);
      wr(8'h11, "R2");
      wr(8'h22, "R4");
      load(1, 1, 1, 0);
      load(1, 0, 0, 100);
      wr(8'h33, "R2");

      // R7: column beyond the array, then bank beyond the array
      load(1, 0, 0, 5);
      load(0, 1, 0, 1);
      wr(8'h44, "R7");
      wr(8'h45, "R7");
      load(1, 0, 0, 2);
      wr(8'h46, "R7");
      load(1, 1, 0, 7);
      load(0, 0, 1, 9);
      wr(8'h47, "R7");
      load(0, 0, 1, 15);
      wr(8'h48, "R7");
      load(0, 0, 1, 2);
      wr(8'h49, "R7");

      // R8: write in the same cycle as a load is dropped
      @(negedge clk);
      wr_en = 1'b1; wr_byte = 8'hEE; ld_y = 1'b1; ld_value = 7'd6;
      @(negedge clk);
      wr_en = 1'b0; ld_y = 1'b0;
      m_y = 6;
      chk(ram_we === 1'b0 && addr_err === 1'b0, "R8", int'(ram_we), 0);
      wr(8'h50, "R8");

      // R5: full vertical sweep
      set_mode(1, 0);
      load(1, 1, 1, 0);
      for (int i = 0; i < 133 * 9 + 5; i++) wr(8'((i * 53) + 8'h17), "R5");
      load(1, 0, 0, 4);
      load(0, 1, 0, 1);
      load(0, 0, 1, 8);
      wr(8'hFF, "R5");
      wr(8'h7F, "R5");

      // R3: mirrored horizontal sweep over two banks
      set_mode(0, 1);
      load(1, 1, 1, 0);
      for (int i = 0; i < 133 * 2 + 3; i++) wr(8'(i), "R3");
      load(1, 0, 0, 4);
      load(0, 1, 0, 1);
      load(0, 0, 1, 8);
      wr(8'hA5, "R3");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule